// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. It copies a programmed number of units from a source region to a destination region over a simple memory bus. Every unit is read from the source into an internal 32-bit holding register and then written to the destination. A unit is one byte, one 16-bit half, one 32-bit word, or a 16-byte block. The 16-byte block is carried as four word reads and writes in turn.

Software loads the source pointer, the destination pointer, the unit count and a control word through a small write port. Setting the run bit starts the transfer. Each pointer can stay fixed, count up or count down on its own. The channel asks for the bus with a request/grant handshake. In steal mode it gives the bus back after every unit. In burst mode it keeps the bus until the last unit is done. Units start on their own when auto-start is set. Otherwise each unit waits for a pulse on a request strobe (steal mode), or the whole run waits for one pulse (burst mode).

The channel raises a sticky half-way flag and a sticky done flag. When the count runs out it clears its own run bit.

Top module: `dma_chan`

## Requirements
- R1: After reset, ch_en, irq_half, irq_done, bus_req, mem_rd and mem_wr are all 0.
- R2: Register writes go to reg_addr 0 (source pointer), 1 (destination pointer), 2 (unit count, low CW bits) and 3 (control). Control bits are: bit 0 run, bit 1 burst, bit 2 auto-start, bits 4:3 unit size, bits 6:5 source mode, bits 8:7 destination mode, bit 16 clear done, bit 17 clear half. While ch_en is 1, writes to the pointers, the count and control bits 8:0 have no effect.
- R3: A run moves exactly N units, where N is the programmed count. A count of 0 means 2^CW units. When the last unit's write completes, ch_en drops to 0 and irq_done is set.
- R4: Unit size encoding is 0 byte, 1 half, 2 word, 3 sixteen bytes. mem_size carries 0, 1 or 2 (1, 2 or 4 bytes). A sixteen-byte unit is done as four word-sized read/write pairs at the unit's pointer plus 0, 4, 8 and 12.
- R5: Mode encoding is 0 fixed, 1 up, 2 down. After each unit, a pointer in up mode grows by the unit's byte count and a pointer in down mode shrinks by it. The source and destination pointers follow their own modes.
- R6: Each access pair is a read of the source followed by a write of the same data to the destination. The write carries the read bytes unchanged in the low bytes of mem_wdata.
- R7: In steal mode, bus_req drops for at least one cycle after every unit, so a run of N units raises bus_req N times.
- R8: In burst mode, bus_req rises once per run and stays high until the last unit is done.
- R9: With auto-start off, no access starts until req is pulsed. In steal mode each pulse releases one unit. In burst mode one pulse releases the whole run. A pulse while ch_en is 0 is ignored.
- R10: irq_half is set when the units done reach N minus floor(N/2).
- R11: Writing 1 to control bit 16 clears irq_done and writing 1 to bit 17 clears irq_half. Writing 0 to those bits leaves the flags set.
- R12: mem_rd and mem_wr are asserted only while bus_gnt is high. An access is held until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| req | input | 1 | Unit request strobe, used when auto-start is off |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Access complete |
| ch_en | output | 1 | Run bit |
| irq_half | output | 1 | Half-way flag |
| irq_done | output | 1 | Done flag |

## Verification
A wrong pointer shows up at mem_addr on the very next read or write after the unit that corrupted it. A slip in the beat counter shows up on the second word of a sixteen-byte unit. A count register that is off by one keeps ch_en high for an extra unit, or drops it one unit early. The bench sees that as an extra or missing write and a done flag in the wrong cycle. A half-way target computed wrongly moves the rise of irq_half away from unit N minus floor(N/2), so it is caught within one run. A fault in the sequencer's release logic changes how many times bus_req rises during a run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    USZ_BYTE = 2'd0,
    USZ_HALF = 2'd1,
    USZ_WORD = 2'd2,
    USZ_QUAD = 2'd3
  } usize_e;

  typedef enum logic [1:0] {
    PM_FIXED = 2'd0,
    PM_UP    = 2'd1,
    PM_DOWN  = 2'd2,
    PM_RSVD  = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARB  = 2'd1,
    SQ_RD   = 2'd2,
    SQ_WR   = 2'd3
  } seq_e;

  // control bits 8:1 map onto this struct, LSB first: burst, auto, size, smode, dmode
  typedef struct packed {
    pmode_e dmode;
    pmode_e smode;
    usize_e usize;
    logic   auto_go;
    logic   burst;
  } cfg_t;

  localparam logic [1:0] RA_SRC = 2'd0;
  localparam logic [1:0] RA_DST = 2'd1;
  localparam logic [1:0] RA_CNT = 2'd2;
  localparam logic [1:0] RA_CTL = 2'd3;

  localparam int CB_RUN  = 0;
  localparam int CB_CLRD = 16;
  localparam int CB_CLRH = 17;

  function automatic logic [4:0] unit_bytes(input usize_e s);
    case (s)
      USZ_BYTE: unit_bytes = 5'd1;
      USZ_HALF: unit_bytes = 5'd2;
      USZ_WORD: unit_bytes = 5'd4;
      default:  unit_bytes = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  pmode_e        mode,
  input  usize_e        usize,
  input  logic [1:0]    beat,
  output logic [AW-1:0] beat_addr
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] delta;

  assign delta = {{(AW-5){1'b0}}, unit_bytes(usize)};

  always_comb begin
    ptr_d = ptr_q;
    if (ld) begin
      ptr_d = ld_val;
    end else if (step) begin
      case (mode)
        PM_UP:   ptr_d = ptr_q + delta;
        PM_DOWN: ptr_d = ptr_q - delta;
        default: ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign beat_addr = ptr_q + {{(AW-4){1'b0}}, beat, 2'b00};

  AST_FIXED_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && mode == PM_FIXED) |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    wsel,
  input  logic [CW-1:0] wcnt,
  input  logic          wrun,
  input  cfg_t          wcfg,
  input  logic          wclr_done,
  input  logic          wclr_half,
  input  logic          unit_done,
  output logic          src_ld,
  output logic          dst_ld,
  output logic          run,
  output cfg_t          cfg,
  output logic          last_unit,
  output logic          done_flag,
  output logic          half_flag
);

  localparam logic [CW-1:0] ONE      = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] HALF_MAX = {1'b1, {(CW-1){1'b0}}};

  logic [CW-1:0] cnt_q, cnt_d, tgt_q, tgt_d, cnt_dec;
  logic          run_d, done_d, half_d;
  cfg_t          cfg_d;
  logic          ctl_wr, cfg_open, start;

  assign ctl_wr   = we && (wsel == RA_CTL);
  assign cfg_open = !run;
  assign start    = ctl_wr && cfg_open && wrun;
  assign src_ld   = we && (wsel == RA_SRC) && cfg_open;
  assign dst_ld   = we && (wsel == RA_DST) && cfg_open;
  assign cnt_dec  = cnt_q - ONE;
  assign last_unit = (cnt_q == ONE);

  always_comb begin
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    run_d  = run;
    cfg_d  = cfg;
    done_d = done_flag;
    half_d = half_flag;

    if (we && (wsel == RA_CNT) && cfg_open) cnt_d = wcnt;
    else if (unit_done)                     cnt_d = cnt_dec;

    if (ctl_wr && cfg_open) begin
      cfg_d = wcfg;
      run_d = wrun;
    end
    if (start) tgt_d = (cnt_q == '0) ? HALF_MAX : (cnt_q >> 1);

    if (unit_done && last_unit) run_d = 1'b0;

    if (unit_done && last_unit)   done_d = 1'b1;
    else if (ctl_wr && wclr_done) done_d = 1'b0;

    if (unit_done && (cnt_dec == tgt_q)) half_d = 1'b1;
    else if (ctl_wr && wclr_half)        half_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tgt_q     <= '0;
      run       <= 1'b0;
      cfg       <= '0;
      done_flag <= 1'b0;
      half_flag <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      tgt_q     <= tgt_d;
      run       <= run_d;
      cfg       <= cfg_d;
      done_flag <= done_d;
      half_flag <= half_d;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg)); // R2

  AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !run); // R3

  AST_NO_COUNT_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !unit_done && !(we && wsel == RA_CNT)) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        burst,
  input  logic        auto_go,
  input  usize_e      usize,
  input  logic        last_unit,
  input  logic        req,
  input  logic        bus_gnt,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        bus_req,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [1:0]  beat,
  output logic [31:0] hold,
  output logic        unit_done
);

  seq_e        st_q, st_d;
  logic [1:0]  beat_d;
  logic [31:0] hold_d;
  logic        pend_q, pend_d;
  logic        go, take, last_beat;

  assign go        = run && (auto_go || pend_q);
  assign take      = (st_q == SQ_IDLE) && go;
  assign last_beat = (usize != USZ_QUAD) || (beat == 2'd3);
  assign unit_done = (st_q == SQ_WR) && mem_ack && last_beat;
  assign pend_d    = run && ((pend_q && !take) || req);

  always_comb begin
    st_d   = st_q;
    beat_d = beat;
    case (st_q)
      SQ_IDLE: if (go) st_d = SQ_ARB;
      SQ_ARB:  if (bus_gnt) st_d = SQ_RD;
      SQ_RD:   if (mem_ack) st_d = SQ_WR;
      SQ_WR: begin
        if (mem_ack) begin
          if (!last_beat) begin
            beat_d = beat + 2'd1;
            st_d   = SQ_RD;
          end else begin
            beat_d = 2'd0;
            st_d   = (burst && !last_unit) ? SQ_RD : SQ_IDLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  assign hold_d = (st_q == SQ_RD && mem_ack) ? mem_rdata : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      beat   <= 2'd0;
      pend_q <= 1'b0;
      hold   <= '0;
    end else begin
      st_q   <= st_d;
      beat   <= beat_d;
      pend_q <= pend_d;
      hold   <= hold_d;
    end
  end

  assign bus_req = (st_q != SQ_IDLE);
  assign mem_rd  = (st_q == SQ_RD);
  assign mem_wr  = (st_q == SQ_WR);

  AST_ACCESS_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_gnt); // R12

  AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> mem_rd); // R12

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !burst) |=> !bus_req); // R7

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && burst && !last_unit) |=> (bus_req && mem_rd)); // R8

  AST_STOPPED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !mem_wr) |-> !mem_rd); // R3

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  input  logic          req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          ch_en,
  output logic          irq_half,
  output logic          irq_done
);

  logic [1:0]    rst_sync;
  logic          rst_l;
  logic          src_ld, dst_ld, last_unit, unit_done;
  cfg_t          cfg;
  logic [1:0]    beat;
  logic [AW-1:0] src_addr, dst_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  dma_chan_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_l),
    .we        (reg_we),
    .wsel      (reg_addr),
    .wcnt      (reg_wdata[CW-1:0]),
    .wrun      (reg_wdata[CB_RUN]),
    .wcfg      (cfg_t'(reg_wdata[8:1])),
    .wclr_done (reg_wdata[CB_CLRD]),
    .wclr_half (reg_wdata[CB_CLRH]),
    .unit_done (unit_done),
    .src_ld    (src_ld),
    .dst_ld    (dst_ld),
    .run       (ch_en),
    .cfg       (cfg),
    .last_unit (last_unit),
    .done_flag (irq_done),
    .half_flag (irq_half)
  );

  dma_chan_ptr #(.AW(AW)) u_src (
    .clk       (clk),
    .rst_n     (rst_l),
    .ld        (src_ld),
    .ld_val    (reg_wdata),
    .step      (unit_done),
    .mode      (cfg.smode),
    .usize     (cfg.usize),
    .beat      (beat),
    .beat_addr (src_addr)
  );

  dma_chan_ptr #(.AW(AW)) u_dst (
    .clk       (clk),
    .rst_n     (rst_l),
    .ld        (dst_ld),
    .ld_val    (reg_wdata),
    .step      (unit_done),
    .mode      (cfg.dmode),
    .usize     (cfg.usize),
    .beat      (beat),
    .beat_addr (dst_addr)
  );

  dma_chan_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_l),
    .run       (ch_en),
    .burst     (cfg.burst),
    .auto_go   (cfg.auto_go),
    .usize     (cfg.usize),
    .last_unit (last_unit),
    .req       (req),
    .bus_gnt   (bus_gnt),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .bus_req   (bus_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .beat      (beat),
    .hold      (mem_wdata),
    .unit_done (unit_done)
  );

  assign mem_addr = mem_rd ? src_addr : dst_addr;
  assign mem_size = (cfg.usize == USZ_QUAD) ? 2'd2 : cfg.usize;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_l)
    !(mem_rd && mem_wr)); // R6

  AST_QUAD_WORDS: assert property (@(posedge clk) disable iff (!rst_l)
    ((mem_rd || mem_wr) && cfg.usize == USZ_QUAD) |-> (mem_size == 2'd2 && mem_addr[1:0] == src_addr[1:0])); // R4

endmodule

// File: tb/tb_dma_chan.sv
module tb_dma_chan;

  localparam int AW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          req = 1'b0;
  logic          bus_req, bus_gnt;
  logic          mem_rd, mem_wr, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          ch_en, irq_half, irq_done;

  always #2 clk = ~clk;

  dma_chan #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req(req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ch_en(ch_en), .irq_half(irq_half), .irq_done(irq_done)
  );

  // memory and bus model
  logic [7:0] mem [0:1023];
  logic       ws_phase = 1'b0;
  logic       wait_en = 1'b0;
  logic       gnt_q = 1'b0;

  assign bus_gnt = gnt_q;
  assign mem_ack = (mem_rd | mem_wr) & (ws_phase | ~wait_en);

  always_comb begin
    for (int k = 0; k < 4; k++)
      mem_rdata[8*k +: 8] = mem[(mem_addr[9:0] + 10'(k))];
  end

  always @(posedge clk) begin
    ws_phase <= ~ws_phase;
    gnt_q    <= rst_n ? bus_req : 1'b0;
    if (mem_wr && mem_ack) begin
      for (int k = 0; k < 4; k++)
        if (k < (1 << mem_size)) mem[(mem_addr[9:0] + 10'(k))] <= mem_wdata[8*k +: 8];
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int beats_of(input int sz);
    return (sz == 3) ? 4 : 1;
  endfunction

  function automatic int bytes_of(input int sz);
    return (sz == 3) ? 16 : (1 << sz);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int mode,
                                           input int idx, input int sz);
    int k, b;
    logic [31:0] off;
    k = idx / beats_of(sz);
    b = idx % beats_of(sz);
    off = 32'(k * bytes_of(sz));
    case (mode)
      1:       exp_addr = base + off + 32'(4*b);
      2:       exp_addr = base - off + 32'(4*b);
      default: exp_addr = base + 32'(4*b);
    endcase
  endfunction

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a[9:0] * 7 + 3) & 8'hFF);
  endfunction

  // expectations of the run in progress
  logic [31:0] e_src, e_dst;
  int e_sm, e_dm, e_sz;
  bit mon_on = 0;
  int rd_cnt, wr_cnt, units, req_rises, half_at;
  bit prev_req, prev_half;

  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_rd && mem_ack) begin
        chk(mem_addr == exp_addr(e_src, e_sm, rd_cnt, e_sz), "R5", "read address",
            mem_addr, exp_addr(e_src, e_sm, rd_cnt, e_sz));
        chk(mem_size == ((e_sz == 3) ? 2'd2 : 2'(e_sz)), "R4", "read size",
            mem_size, (e_sz == 3) ? 2 : e_sz);
        rd_cnt++;
      end
      if (mem_wr && mem_ack) begin
        logic [31:0] sa, ew, mask;
        sa = exp_addr(e_src, e_sm, wr_cnt, e_sz);
        ew = {pat(sa + 3), pat(sa + 2), pat(sa + 1), pat(sa)};
        mask = (e_sz == 0) ? 32'hFF : (e_sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        chk(mem_addr == exp_addr(e_dst, e_dm, wr_cnt, e_sz), "R5", "write address",
            mem_addr, exp_addr(e_dst, e_dm, wr_cnt, e_sz));
        chk((mem_wdata & mask) == (ew & mask), "R6", "write data",
            mem_wdata & mask, ew & mask);
        chk(wr_cnt + 1 == rd_cnt, "R6", "read precedes write", rd_cnt, wr_cnt + 1);
        wr_cnt++;
        if (wr_cnt % beats_of(e_sz) == 0) units++;
      end
      if (bus_req && !prev_req) req_rises++;
      if (irq_half && !prev_half) half_at = units;
    end
    prev_req  = bus_req;
    prev_half = irq_half;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic start_xfer(input logic [31:0] s, input logic [31:0] d, input int n,
                            input int sz, input int sm, input int dm,
                            input bit burst, input bit autog);
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i));
    e_src = s; e_dst = d; e_sm = sm; e_dm = dm; e_sz = sz;
    rd_cnt = 0; wr_cnt = 0; units = 0; req_rises = 0; half_at = -1;
    mon_on = 1;
    wr_reg(2'd0, s);
    wr_reg(2'd1, d);
    wr_reg(2'd2, 32'(n % (1 << CW)));
    wr_reg(2'd3, 32'(1 | (burst << 1) | (autog << 2) | (sz << 3) | (sm << 5) | (dm << 7)));
  endtask

  task automatic finish_xfer(input int n, input bit burst);
    int guard;
    guard = 0;
    while (ch_en && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 5000, "R3", "run ends", guard, 5000);
    repeat (3) @(negedge clk);
    chk(units == n, "R3", "unit count", units, n);
    chk(rd_cnt == n * beats_of(e_sz), "R4", "read beats", rd_cnt, n * beats_of(e_sz));
    chk(ch_en == 1'b0 && irq_done == 1'b1, "R3", "run bit/done", {ch_en, irq_done}, 2'b01);
    if (burst) chk(req_rises == 1, "R8", "bus requests", req_rises, 1);
    else       chk(req_rises == n, "R7", "bus requests", req_rises, n);
    chk(half_at == n - n / 2, "R10", "half point", half_at, n - n / 2);
    mon_on = 0;
    wr_reg(2'd3, 32'h0003_0000);
    @(negedge clk);
    chk(irq_done == 1'b0 && irq_half == 1'b0, "R11", "flags cleared", {irq_done, irq_half}, 0);
  endtask

  function automatic logic [31:0] sbase(input int m);
    return (m == 1) ? 32'h040 : (m == 2) ? 32'h1C0 : 32'h100;
  endfunction

  function automatic logic [31:0] dbase(input int m);
    return (m == 1) ? 32'h240 : (m == 2) ? 32'h3C0 : 32'h300;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ch_en == 0 && irq_half == 0 && irq_done == 0, "R1", "flags in reset",
        {ch_en, irq_half, irq_done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(bus_req == 0 && mem_rd == 0 && mem_wr == 0 && ch_en == 0, "R1", "idle after reset",
        {bus_req, mem_rd, mem_wr, ch_en}, 0);

    // sweep: every size, both pointer modes, both bus modes, auto-start
    for (int sz = 0; sz < 4; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int b = 0; b < 2; b++) begin
            int n;
            n = 1 + ((sz * 9 + sm * 3 + dm + b) % 5);
            wait_en = ((sm + dm) % 2) == 1;
            start_xfer(sbase(sm), dbase(dm), n, sz, sm, dm, b[0], 1'b1);
            finish_xfer(n, b[0]);
          end
    wait_en = 1'b0;

    // count of zero means 2^CW units
    start_xfer(32'h040, 32'h240, 1 << CW, 0, 1, 1, 1'b0, 1'b1);
    finish_xfer(1 << CW, 1'b0);

    // R9: request strobe in steal mode, with R2 frozen writes in between
    pulse_req();
    start_xfer(32'h040, 32'h240, 3, 1, 1, 1, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk(rd_cnt == 0 && ch_en == 1, "R9", "waits for strobe", rd_cnt, 0);
    wr_reg(2'd0, 32'h000);
    wr_reg(2'd1, 32'h000);
    wr_reg(2'd2, 32'd9);
    wr_reg(2'd3, 32'h0000_0018);
    @(negedge clk);
    chk(ch_en == 1, "R2", "run bit kept while enabled", ch_en, 1);
    chk(rd_cnt == 0, "R2", "frozen writes start nothing", rd_cnt, 0);
    pulse_req();
    repeat (15) @(negedge clk);
    chk(units == 1 && ch_en == 1, "R9", "one unit per strobe", units, 1);
    pulse_req();
    repeat (15) @(negedge clk);
    chk(units == 2, "R9", "second strobe", units, 2);
    pulse_req();
    finish_xfer(3, 1'b0);

    // R9: one strobe releases a whole burst
    start_xfer(32'h040, 32'h240, 4, 2, 1, 2, 1'b1, 1'b0);
    repeat (8) @(negedge clk);
    chk(rd_cnt == 0, "R9", "burst waits for strobe", rd_cnt, 0);
    pulse_req();
    finish_xfer(4, 1'b1);

    // R11: write-one-to-clear, zero leaves the flags alone
    start_xfer(32'h040, 32'h240, 2, 0, 1, 1, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    mon_on = 0;
    wr_reg(2'd3, 32'h0000_0000);
    @(negedge clk);
    chk(irq_done == 1 && irq_half == 1, "R11", "zero write keeps flags", {irq_done, irq_half}, 3);
    wr_reg(2'd3, 32'h0002_0000);
    @(negedge clk);
    chk(irq_done == 1 && irq_half == 0, "R11", "half cleared alone", {irq_done, irq_half}, 2);
    wr_reg(2'd3, 32'h0001_0000);
    @(negedge clk);
    chk(irq_done == 0, "R11", "done cleared", irq_done, 0);

    if (!summary_done) begin
      summary_done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
    $finish;
  end

endmodule